// File: doc/BRIEF.md
# Synthesizer Divider Power-Down Controller

This block governs the reference divider and the feedback divider of a frequency synthesizer. Both dividers are modelled as programmable counters clocked by the system clock. Each emits a one-cycle phase-detector pulse once per programmed period. A chip-enable pin and two mode bits, counter-clear and power-down, pick one of four operating modes: running, charge-pump-gated power-down, counter clear, and immediate power-down. In every mode other than running, both dividers are parked at zero. When the block leaves such a mode, the two dividers start together from zero, so their phase relation is known.

The mode bits and the two divide values arrive through a three-wire serial port made of clock, data and latch. The port keeps working in every power-down mode, so software can reprogram the synthesizer while it sleeps. The charge-pump pulse is an input strobe that is high while a pulse is in progress. Gated power-down takes effect only at the falling edge of that strobe, or at the next divider pulse if no strobe is active. A 2-bit status output reports the mode in force.

Top module: `synth_pd_ctrl`

## Requirements
- R1: With chip_en high and both mode bits 0, the block runs and mode reads 2'b00.
- R2: While running, ref_pulse is high for one cycle every R cycles of clk. It first rises R-1 cycles after the counters leave a hold. An R value of 0 acts as 1.
- R3: While running, fb_pulse follows the same rule with the N divide value.
- R4: With chip_en high, counter-clear 0 and power-down 1, the block keeps running (mode 2'b00) while cp_pulse stays high. It enters gated power-down (mode 2'b01) one cycle after cp_pulse falls.
- R5: If cp_pulse is low when gated power-down is requested, the block enters it (mode 2'b01) one cycle after the first ref_pulse or fb_pulse.
- R6: With chip_en high, counter-clear 1 and power-down 0, mode reads 2'b10 and neither divider pulses.
- R7: With chip_en high and both mode bits 1, mode reads 2'b11 as soon as the word is latched, with no wait on cp_pulse.
- R8: With chip_en low, mode reads 2'b11 whatever the mode bits hold, and neither divider pulses.
- R9: The shift register takes ser_data on each rising ser_clk, most significant bit first. A 12-bit word carries its address in bits [1:0]. In the R word, bits [9:2] hold R. In the N word, bit 2 is power-down, bit 3 is counter-clear and bits [11:4] hold N.
- R10: A rising ser_le copies the word into the R register when the address is 2'b00, and into the N register when it is 2'b01. Addresses 2'b10 and 2'b11 change nothing.
- R11: Words latched while chip_en is low take effect once chip_en rises.
- R12: When the block leaves any hold, both dividers restart from zero in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_en | input | 1 | Chip enable; low forces immediate power-down |
| ser_clk | input | 1 | Serial shift clock, sampled by clk |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Serial latch enable; rising edge loads the addressed register |
| cp_pulse | input | 1 | High while a charge-pump pulse is in progress |
| ref_pulse | output | 1 | Reference divider phase-detector pulse |
| fb_pulse | output | 1 | Feedback divider phase-detector pulse |
| mode | output | 2 | Mode in force: 00 run, 01 gated power-down, 10 counter clear, 11 immediate power-down |

## Verification
Some properties are checked on every cycle. No divider pulses in a non-running mode. A held counter sits at zero on the next cycle. Gated power-down begins only after a cycle with the request present and cp_pulse low. Each serial clock edge shifts the current data bit into the bottom of the register. Unused addresses leave the stored words unchanged. Other behaviour needs the bench's scenarios: the exact pulse periods and their alignment after a hold, the cycle at which gated power-down takes hold in each of its two cases, the mode decode for all combinations of inputs, and programming that takes effect only after chip enable returns.

// File: rtl/synth_pd_pkg.sv
package synth_pd_pkg;
  typedef enum logic [1:0] {
    MODE_RUN      = 2'b00,
    MODE_GATED_PD = 2'b01,
    MODE_CNT_CLR  = 2'b10,
    MODE_IMMED_PD = 2'b11
  } pd_mode_e;

  localparam logic [1:0] ADDR_R_WORD = 2'b00;
  localparam logic [1:0] ADDR_N_WORD = 2'b01;
endpackage

// File: rtl/pdc_serial_port.sv
module pdc_serial_port
  import synth_pd_pkg::*;
#(
  parameter int R_W = 8,
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_le,
  output logic [R_W-1:0] r_div,
  output logic [N_W-1:0] n_div,
  output logic           cnt_clr,
  output logic           pwr_dn
);
  localparam int PAY_W = (R_W > N_W + 2) ? R_W : N_W + 2;
  localparam int SR_W  = PAY_W + 2;

  logic            sc_q, le_q;
  logic [SR_W-1:0] sr_q, sr_d;
  logic [R_W-1:0]  r_div_q, r_div_d;
  logic [N_W-1:0]  n_div_q, n_div_d;
  logic            clr_q, clr_d, pd_q, pd_d;
  logic            shift_en, load_en;
  logic [PAY_W-1:0] payload;
  logic [1:0]      addr;

  always_comb begin
    shift_en = ser_clk & ~sc_q;
    load_en  = ser_le & ~le_q;
    payload  = sr_q[SR_W-1:2];
    addr     = sr_q[1:0];
    sr_d     = sr_q;
    if (shift_en) sr_d = {sr_q[SR_W-2:0], ser_data};
    r_div_d = r_div_q;
    n_div_d = n_div_q;
    clr_d   = clr_q;
    pd_d    = pd_q;
    if (load_en) begin
      case (addr)
        ADDR_R_WORD: r_div_d = payload[R_W-1:0];
        ADDR_N_WORD: begin
          pd_d    = payload[0];
          clr_d   = payload[1];
          n_div_d = payload[N_W+1:2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q    <= 1'b0;
      le_q    <= 1'b0;
      sr_q    <= '0;
      r_div_q <= R_W'(1);
      n_div_q <= N_W'(1);
      clr_q   <= 1'b0;
      pd_q    <= 1'b0;
    end else begin
      sc_q    <= ser_clk;
      le_q    <= ser_le;
      sr_q    <= sr_d;
      r_div_q <= r_div_d;
      n_div_q <= n_div_d;
      clr_q   <= clr_d;
      pd_q    <= pd_d;
    end
  end

  assign r_div   = r_div_q;
  assign n_div   = n_div_q;
  assign cnt_clr = clr_q;
  assign pwr_dn  = pd_q;

  // R9: the bit present at a serial clock rise lands in the bottom of the register
  p_shift_msb_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sr_q[0] == $past(ser_data)));

  // R10: unused addresses leave every stored word alone
  p_bad_addr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && addr[1]) |=> ($stable(r_div_q) && $stable(n_div_q) &&
                              $stable(clr_q) && $stable(pd_q)));
endmodule

// File: rtl/pdc_mode_ctrl.sv
module pdc_mode_ctrl
  import synth_pd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     chip_en,
  input  logic     cnt_clr,
  input  logic     pwr_dn,
  input  logic     cp_pulse,
  input  logic     ref_tc,
  input  logic     fb_tc,
  output pd_mode_e mode,
  output logic     hold
);
  logic cp_q;
  logic gated_q, gated_d;
  logic gated_req;

  always_comb begin
    gated_req = chip_en & ~cnt_clr & pwr_dn;
    gated_d   = gated_req & (gated_q | (~cp_pulse & (cp_q | ref_tc | fb_tc)));
    if (!chip_en)                mode = MODE_IMMED_PD;
    else if (cnt_clr && pwr_dn)  mode = MODE_IMMED_PD;
    else if (cnt_clr)            mode = MODE_CNT_CLR;
    else if (pwr_dn && gated_q)  mode = MODE_GATED_PD;
    else                         mode = MODE_RUN;
    hold = (mode != MODE_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_q    <= 1'b0;
      gated_q <= 1'b0;
    end else begin
      cp_q    <= cp_pulse;
      gated_q <= gated_d;
    end
  end

  // R4 / R5: gated power-down starts only after a requested cycle with no pump pulse
  p_gated_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gated_q) |-> ($past(gated_req) && !$past(cp_pulse)));
endmodule

// File: rtl/pdc_div_counter.sv
module pdc_div_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] div,
  output logic         tc
);
  logic [W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim = (div == '0) ? '0 : div - W'(1);
    tc  = ~hold & (cnt_q == lim);
    if (hold || tc) cnt_d = '0;
    else            cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R12: a held divider sits at its zero load point on the following cycle
  p_held_at_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0));
endmodule

// File: rtl/synth_pd_ctrl.sv
module synth_pd_ctrl
  import synth_pd_pkg::*;
#(
  parameter int R_W = 8,
  parameter int N_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_en,
  input  logic       ser_clk,
  input  logic       ser_data,
  input  logic       ser_le,
  input  logic       cp_pulse,
  output logic       ref_pulse,
  output logic       fb_pulse,
  output logic [1:0] mode
);
  logic [1:0]     rs_q;
  logic           rst_sync_n;
  logic [R_W-1:0] r_div;
  logic [N_W-1:0] n_div;
  logic           cnt_clr, pwr_dn, hold;
  pd_mode_e       mode_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  pdc_serial_port #(.R_W(R_W), .N_W(N_W)) u_port (
    .clk(clk), .rst_n(rst_sync_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .r_div(r_div), .n_div(n_div), .cnt_clr(cnt_clr), .pwr_dn(pwr_dn)
  );

  pdc_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_sync_n), .chip_en(chip_en), .cnt_clr(cnt_clr),
    .pwr_dn(pwr_dn), .cp_pulse(cp_pulse), .ref_tc(ref_pulse), .fb_tc(fb_pulse),
    .mode(mode_e), .hold(hold)
  );

  pdc_div_counter #(.W(R_W)) u_ref_div (
    .clk(clk), .rst_n(rst_sync_n), .hold(hold), .div(r_div), .tc(ref_pulse)
  );

  pdc_div_counter #(.W(N_W)) u_fb_div (
    .clk(clk), .rst_n(rst_sync_n), .hold(hold), .div(n_div), .tc(fb_pulse)
  );

  assign mode = mode_e;

  // R6 / R8: no phase-detector pulse leaves a held divider pair
  p_no_pulse_held_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode != MODE_RUN) |-> (!ref_pulse && !fb_pulse));

  // R8: chip enable low always reads as immediate power-down
  p_chip_off_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !chip_en |-> (mode == MODE_IMMED_PD));
endmodule

// File: tb/tb_synth_pd_ctrl.sv
module tb_synth_pd_ctrl;
  logic clk = 1'b0;
  logic rst_n, chip_en, ser_clk, ser_data, ser_le, cp_pulse;
  logic ref_pulse, fb_pulse;
  logic [1:0] mode;
  int vectors = 0;
  int miscmp  = 0;
  int seed;

  always #4 clk = ~clk;

  synth_pd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_le(ser_le), .cp_pulse(cp_pulse),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .mode(mode)
  );

  function automatic int exp_mode(input bit ce, input bit clr, input bit pd, input bit entered);
    if (!ce)        return 3;
    if (clr && pd)  return 3;
    if (clr)        return 2;
    if (pd && entered) return 1;
    return 0;
  endfunction

  function automatic int eff_div(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [1:0] addr, input logic [9:0] payload);
    logic [11:0] w;
    w = {payload, addr};
    for (int i = 11; i >= 0; i--) begin
      @(negedge clk); ser_data = w[i]; ser_clk = 1'b1;
      @(negedge clk); ser_clk = 1'b0;
    end
    @(negedge clk); ser_le = 1'b1;
    @(negedge clk); ser_le = 1'b0;
  endtask

  task automatic load_r(input int v);
    logic [7:0] b;
    b = v[7:0];
    send_word(2'b00, {2'b00, b});
  endtask

  task automatic load_n(input int v, input bit clr, input bit pd);
    logic [7:0] b;
    b = v[7:0];
    send_word(2'b01, {b, clr, pd});
  endtask

  // starts at j = 0, the first cycle after a hold was left
  task automatic check_periods(input string tag, input int r, input int n, input int cycles);
    int er, en;
    er = eff_div(r); en = eff_div(n);
    for (int j = 0; j < cycles; j++) begin
      #1;
      chk({tag, " ref_pulse"}, int'(ref_pulse), ((j % er) == er - 1) ? 1 : 0);
      chk({tag, " fb_pulse"},  int'(fb_pulse),  ((j % en) == en - 1) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic check_quiet(input string tag, input int exp_m, input int cycles);
    for (int j = 0; j < cycles; j++) begin
      #1;
      chk({tag, " mode"}, int'(mode), exp_m);
      chk({tag, " pulses"}, int'(ref_pulse | fb_pulse), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    seed = $urandom(32'h5eed);
    rst_n = 1'b0; chip_en = 1'b1; ser_clk = 1'b0; ser_data = 1'b0;
    ser_le = 1'b0; cp_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state runs with divide 1 on both counters
    #1;
    chk("R1 reset mode", int'(mode), 0);
    chk("R2 reset ref_pulse", int'(ref_pulse), 1);
    chk("R3 reset fb_pulse", int'(fb_pulse), 1);
    @(negedge clk);

    // R2 R3 R9 R10: program dividers from a clear, then run aligned
    load_n(5, 1'b1, 1'b0);
    #1; chk("R6 counter clear mode", int'(mode), 2);
    @(negedge clk);
    check_quiet("R6 clear", 2, 4);
    load_r(3);
    load_n(5, 1'b0, 1'b0);
    #1; chk("R1 run mode", int'(mode), 0);
    check_periods("R2 R3 R12 run 3/5", 3, 5, 16);

    // R10: unused addresses change nothing
    load_n(5, 1'b1, 1'b0);
    send_word(2'b10, 10'h3ff);
    send_word(2'b11, 10'h155);
    #1; chk("R10 ignored addr mode", int'(mode), 2);
    @(negedge clk);
    load_n(5, 1'b0, 1'b0);
    check_periods("R10 ignored addr", 3, 5, 12);

    // R2: R value 0 behaves as 1
    load_n(4, 1'b1, 1'b0);
    load_r(0);
    load_n(4, 1'b0, 1'b0);
    check_periods("R2 zero divide", 0, 4, 8);

    // R4: gated power-down waits for the pump pulse to end
    load_n(5, 1'b1, 1'b0);
    load_r(3);
    cp_pulse = 1'b1;
    @(negedge clk);
    load_n(5, 1'b0, 1'b1);
    for (int j = 0; j < 7; j++) begin
      #1; chk("R4 pending mode", int'(mode), 0);
      @(negedge clk);
    end
    cp_pulse = 1'b0;
    #1; chk("R4 before fall seen", int'(mode), 0);
    @(negedge clk);
    check_quiet("R4 gated entry", 1, 3);

    // R5: no pump pulse, entry after the first divider pulse (R=3 -> j=2)
    load_n(5, 1'b1, 1'b0);
    load_n(5, 1'b0, 1'b1);
    for (int j = 0; j < 3; j++) begin
      #1;
      chk("R5 pending mode", int'(mode), 0);
      chk("R5 pending ref_pulse", int'(ref_pulse), (j == 2) ? 1 : 0);
      @(negedge clk);
    end
    check_quiet("R5 gated entry", 1, 3);

    // R7: both bits set -> immediate power-down
    cp_pulse = 1'b1;
    load_n(5, 1'b0, 1'b0);
    load_n(5, 1'b1, 1'b1);
    check_quiet("R7 immediate", 3, 4);
    load_n(5, 1'b0, 1'b0);
    check_periods("R12 restart after immediate", 3, 5, 10);

    // R8 R11: chip enable low overrides, serial still loads
    chip_en = 1'b0;
    check_quiet("R8 chip off", 3, 3);
    load_n(5, 1'b1, 1'b0);
    #1; chk("R8 chip off clr", int'(mode), 3);
    @(negedge clk);
    load_r(4);
    load_n(6, 1'b0, 1'b0);
    #1; chk("R8 chip off run bits", int'(mode), 3);
    @(negedge clk);
    chip_en = 1'b1;
    check_periods("R11 load while off", 4, 6, 14);

    // R2 R3 R12: random divide values
    cp_pulse = 1'b0;
    for (int k = 0; k < 6; k++) begin
      int rv, nv;
      rv = $urandom_range(1, 9);
      nv = $urandom_range(1, 9);
      load_n(nv, 1'b1, 1'b0);
      load_r(rv);
      load_n(nv, 1'b0, 1'b0);
      check_periods("R2 R3 random", rv, nv, 20);
    end

    // R1 R6 R7 R8: random mode decode with the pump held busy
    cp_pulse = 1'b1;
    load_n(3, 1'b1, 1'b0);
    for (int k = 0; k < 16; k++) begin
      bit ce, clr, pd;
      ce  = 1'($urandom_range(0, 3) != 0);
      clr = 1'($urandom_range(0, 1));
      pd  = 1'($urandom_range(0, 1));
      chip_en = ce;
      load_n(3, clr, pd);
      #1;
      chk("R1 R6 R7 R8 decode", int'(mode), exp_mode(ce, clr, pd, 1'b0));
      @(negedge clk);
      chip_en = 1'b1;
      load_n(3, 1'b1, 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule